// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

This block holds the 16-bit value registers of a four-channel timer, reached over an 8-bit register bus. Each channel runs in one of two modes picked by its own mode bit. In capture mode, a strobe from an external edge detector stores the present value of the free-running counter into the channel. In compare mode, software loads the register, and the channel raises a match output while the counter equals the stored value. Edge polarity, pin actions, interrupt flags and the counter itself live outside this block. The counter value and the per-channel capture strobes arrive as plain inputs.

The bus window has sixteen byte offsets, which form eight channel slots. Only the first four slots are real. A slot's high byte sits at the even offset and its low byte at the odd offset. Two shared holding bytes keep 16-bit values coherent across byte accesses:

- A high-byte read stores the low byte, so the following low-byte read returns a value taken in the same instant.
- A high-byte write is held until the low-byte write, and the two bytes then enter the register together.

Software must therefore touch the high byte first.

The bus has no handshake and no back-pressure. An access is presented with `bus_sel` for one clock cycle and completes in that cycle. Read data is valid combinationally while `bus_sel` is high and `bus_wr` is low, and reads zero at all other times.

Top module: `tmr_chan_bank`

## Requirements
- R1: Mode bit `mode_oc[i]` = 1 puts channel i in compare mode and 0 puts it in capture mode. A capture strobe has no effect on a channel that is in compare mode.
- R2: In capture mode, `cap_evt[i]` high at a clock edge loads `cnt_val` into channel i's register at that edge.
- R3: In capture mode, bus writes never change the channel register.
- R4: In compare mode, a low-byte write loads the register in one edge with {held high byte, written low byte}.
- R5: After reset every channel register, and both holding bytes, are 0x0000 / 0x00.
- R6: Offset bits [3:1] select the slot. Offset bit 0 = 0 selects the high byte and bit 0 = 1 selects the low byte.
- R7: Slots 4 to 7 read as 0x00. Writes to them change no register and no holding byte.
- R8: A high-byte read of a real channel copies that channel's low byte into the read holding byte. A low-byte read returns the holding byte, not the live register.
- R9: `cmp_match[i]` is high in exactly the cycles where channel i is in compare mode and `cnt_val` equals its register. It is always low in capture mode.
- R10: When a capture strobe and a low-byte write hit the same capture-mode channel in one cycle, the register takes the counter value.
- R11: A high-byte write alone leaves the channel register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| cnt_val | input | 16 | Free-running counter value |
| cap_evt | input | 4 | Per-channel qualified edge strobes |
| mode_oc | input | 4 | Per-channel mode: 1 compare, 0 capture |
| cmp_match | output | 4 | Per-channel compare match |

## Verification
Two functions can fall in the same cycle and need arbitration: a capture strobe and a low-byte bus write aimed at the same channel. The bench first parks a high byte. It then drives the capture strobe and the low-byte write on one edge for a capture-mode channel. It judges the result by reading the channel back, high byte first, and expects the counter value rather than the written word. A second, related collision is covered too: a capture that lands between a high-byte read and its low-byte read. Here the bench expects the low byte to come from the holding byte, not from the new capture.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  // byte-half select carried in offset bit 0
  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} half_e;

  // decoded bus access for one cycle
  typedef struct packed {
    logic  real_slot;  // slot maps to an existing channel
    half_e half;
    logic  rd;
    logic  wr;
  } acc_t;
endpackage

// File: rtl/tcb_addr_dec.sv
`timescale 1ns/1ps
module tcb_addr_dec
  import tcb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 3
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [SLOT_W:0]   bus_addr,
  output logic [NUM_CH-1:0] ch_oh,
  output acc_t              acc
);
  logic [SLOT_W-1:0] slot;
  assign slot = bus_addr[SLOT_W:1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_oh
    assign ch_oh[i] = (slot == SLOT_W'(i));
  end

  always_comb begin
    acc.real_slot = (slot < SLOT_W'(NUM_CH));
    acc.half      = half_e'(bus_addr[0]);
    acc.rd        = bus_sel && !bus_wr;
    acc.wr        = bus_sel &&  bus_wr;
  end
endmodule

// File: rtl/tcb_byte_stage.sv
`timescale 1ns/1ps
module tcb_byte_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          park_wr,   // high-byte write to a real slot
  input  logic [DW-1:0] wr_byte,
  input  logic          park_rd,   // high-byte read of a real slot
  input  logic [DW-1:0] rd_byte,   // live low byte of the addressed channel
  output logic [DW-1:0] wr_hold,
  output logic [DW-1:0] rd_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hold <= '0;
      rd_hold <= '0;
    end else begin
      if (park_wr) wr_hold <= wr_byte;
      if (park_rd) rd_hold <= rd_byte;
    end
  end
endmodule

// File: rtl/tcb_channel.sv
`timescale 1ns/1ps
module tcb_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_oc,
  input  logic          cap_evt,
  input  logic [CW-1:0] cnt_val,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] val_q,
  output logic          match
);
  // capture mode accepts only the edge strobe; compare mode only the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (!mode_oc) begin
      if (cap_evt) val_q <= cnt_val;
    end else if (ld_en) begin
      val_q <= ld_val;
    end
  end

  assign match = mode_oc && (cnt_val == val_q);
endmodule

// File: rtl/tmr_chan_bank.sv
`timescale 1ns/1ps
module tmr_chan_bank
  import tcb_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_SLOT = 8,
  parameter int DW       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [$clog2(NUM_SLOT):0]     bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic [DW-1:0]                 bus_rdata,
  input  logic [2*DW-1:0]               cnt_val,
  input  logic [NUM_CH-1:0]             cap_evt,
  input  logic [NUM_CH-1:0]             mode_oc,
  output logic [NUM_CH-1:0]             cmp_match
);
  localparam int CW     = 2 * DW;
  localparam int SLOT_W = $clog2(NUM_SLOT);

  logic [NUM_CH-1:0]         ch_oh;
  acc_t                      acc;
  logic [NUM_CH-1:0][CW-1:0] chan_q;
  logic [CW-1:0]             sel_val;
  logic [DW-1:0]             wr_hold;
  logic [DW-1:0]             rd_hold;
  logic                      park_wr;
  logic                      park_rd;
  logic                      lo_wr;

  tcb_addr_dec #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ch_oh   (ch_oh),
    .acc     (acc)
  );

  // addressed channel's live value (zero for reserved slots)
  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_oh[i]) sel_val = sel_val | chan_q[i];
    end
  end

  assign park_wr = acc.wr && acc.real_slot && (acc.half == HALF_HI);
  assign park_rd = acc.rd && acc.real_slot && (acc.half == HALF_HI);
  assign lo_wr   = acc.wr && acc.real_slot && (acc.half == HALF_LO);

  tcb_byte_stage #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .park_wr(park_wr),
    .wr_byte(bus_wdata),
    .park_rd(park_rd),
    .rd_byte(sel_val[DW-1:0]),
    .wr_hold(wr_hold),
    .rd_hold(rd_hold)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tcb_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_oc(mode_oc[i]),
      .cap_evt(cap_evt[i]),
      .cnt_val(cnt_val),
      .ld_en  (lo_wr && ch_oh[i]),
      .ld_val ({wr_hold, bus_wdata}),
      .val_q  (chan_q[i]),
      .match  (cmp_match[i])
    );
  end

  always_comb begin
    if (!acc.rd || !acc.real_slot) bus_rdata = '0;
    else if (acc.half == HALF_HI)  bus_rdata = sel_val[CW-1:DW];
    else                           bus_rdata = rd_hold;
  end
endmodule

// File: rtl/tcb_chk.sv
`timescale 1ns/1ps
module tcb_chk #(
  parameter int NUM_CH   = 4,
  parameter int NUM_SLOT = 8,
  parameter int DW       = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [$clog2(NUM_SLOT):0]     bus_addr,
  input logic [DW-1:0]                 bus_wdata,
  input logic [DW-1:0]                 bus_rdata,
  input logic [2*DW-1:0]               cnt_val,
  input logic [NUM_CH-1:0]             cap_evt,
  input logic [NUM_CH-1:0]             mode_oc,
  input logic [NUM_CH-1:0]             cmp_match,
  input logic [NUM_CH-1:0][2*DW-1:0]   chan_q,
  input logic [DW-1:0]                 wr_hold
);
  localparam int SLOT_W = $clog2(NUM_SLOT);
  localparam logic [SLOT_W-1:0] FIRST_RES = SLOT_W'(NUM_CH);

  // R7: reserved slots read as zero
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[SLOT_W:1] >= FIRST_RES) |-> bus_rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    logic lo_hit;
    assign lo_hit = bus_sel && bus_wr && (bus_addr == {SLOT_W'(i), 1'b1});

    // R2, R10: capture loads the counter even against a write
    p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_oc[i] && cap_evt[i]) |=> chan_q[i] == $past(cnt_val));

    // R3: capture mode ignores the bus
    p_ic_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_oc[i] && !cap_evt[i]) |=> $stable(chan_q[i]));

    // R4: compare-mode low write loads the held high byte plus new low byte
    p_oc_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oc[i] && lo_hit) |=> chan_q[i] == $past({wr_hold, bus_wdata}));

    // R1, R11: compare mode changes only on a low-byte write
    p_oc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oc[i] && !lo_hit) |=> $stable(chan_q[i]));

    // R9: no match strobe in capture mode
    p_match_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_oc[i] |-> !cmp_match[i]);
  end
endmodule

bind tmr_chan_bank tcb_chk #(.NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT), .DW(DW)) u_chk (.*);

// File: tb/tmr_chan_bank_bench.sv
`timescale 1ns/1ps
module tmr_chan_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_val = '0;
  logic [3:0]  cap_evt = '0, mode_oc = '0, cmp_match;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_chan_bank u_tmr_chan_bank (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_byte(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd_byte(4'(2*ch), h);
    rd_byte(4'(2*ch+1), l);
    v = {h, l};
  endtask

  task automatic wr16(input int ch, input logic [15:0] v);
    wr_byte(4'(2*ch), v[15:8]);
    wr_byte(4'(2*ch+1), v[7:0]);
  endtask

  task automatic pulse_cap(input logic [3:0] m, input logic [15:0] c);
    @(negedge clk); cap_evt = m; cnt_val = c;
    @(negedge clk); cap_evt = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd_byte(4'(a), d);
      chk(d == 8'h00, "R5 reset read", d, 0);
    end
  endtask

  task automatic t_oc_write();
    logic [15:0] v;
    logic [7:0] d;
    mode_oc = 4'b0101;
    wr_byte(4'h0, 8'h12);
    rd16(0, v);
    chk(v == 16'h0000, "R11 high write alone", v, 16'h0000);
    wr_byte(4'h1, 8'h34);
    rd_byte(4'h0, d);
    chk(d == 8'h12, "R6 even offset high byte", d, 8'h12);
    rd_byte(4'h1, d);
    chk(d == 8'h34, "R6 odd offset low byte", d, 8'h34);
    wr16(2, 16'hABCD);
    rd16(2, v);
    chk(v == 16'hABCD, "R4 compare load ch2", v, 16'hABCD);
  endtask

  task automatic t_match();
    @(negedge clk); cnt_val = 16'h1234; #2;
    chk(cmp_match == 4'b0001, "R9 match ch0", cmp_match, 4'b0001);
    @(negedge clk); cnt_val = 16'hABCD; #2;
    chk(cmp_match == 4'b0100, "R9 match ch2", cmp_match, 4'b0100);
    @(negedge clk); cnt_val = 16'h0000; #2;
    chk(cmp_match == 4'b0000, "R9 capture-mode quiet", cmp_match, 0);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    pulse_cap(4'b0010, 16'h5A5A);
    rd16(1, v);
    chk(v == 16'h5A5A, "R2 capture ch1", v, 16'h5A5A);
    pulse_cap(4'b0001, 16'hDEAD);
    rd16(0, v);
    chk(v == 16'h1234, "R1 strobe ignored in compare mode", v, 16'h1234);
    wr16(1, 16'hFFFF);
    rd16(1, v);
    chk(v == 16'h5A5A, "R3 capture-mode write ignored", v, 16'h5A5A);
  endtask

  task automatic t_coherent();
    logic [7:0] d;
    rd_byte(4'h2, d);
    chk(d == 8'h5A, "R8 high read", d, 8'h5A);
    pulse_cap(4'b0010, 16'h7788);
    rd_byte(4'h3, d);
    chk(d == 8'h5A, "R8 low read from holding byte", d, 8'h5A);
    rd_byte(4'h2, d);
    chk(d == 8'h77, "R8 fresh high", d, 8'h77);
    rd_byte(4'h3, d);
    chk(d == 8'h88, "R8 fresh low", d, 8'h88);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    logic [7:0] d;
    wr16(4, 16'hBEEF);
    rd_byte(4'h8, d);
    chk(d == 8'h00, "R7 reserved high read", d, 0);
    rd_byte(4'hF, d);
    chk(d == 8'h00, "R7 reserved low read", d, 0);
    wr_byte(4'h0, 8'h11);
    wr_byte(4'hA, 8'h99);
    wr_byte(4'h1, 8'h22);
    rd16(0, v);
    chk(v == 16'h1122, "R7 reserved write leaves holding byte", v, 16'h1122);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    wr_byte(4'h6, 8'h55);
    @(negedge clk);
    cap_evt = 4'b1000; cnt_val = 16'h0F0F;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h7; bus_wdata = 8'h66;
    @(negedge clk);
    cap_evt = '0; bus_sel = 0; bus_wr = 0;
    rd16(3, v);
    chk(v == 16'h0F0F, "R10 capture wins over write", v, 16'h0F0F);
    mode_oc = 4'b1101;
    wr_byte(4'h7, 8'h66);
    rd16(3, v);
    chk(v == 16'h5566, "R1 mode switch to compare accepts write", v, 16'h5566);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oc_write();
    t_match();
    t_capture();
    t_coherent();
    t_reserved();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule